// File: doc/BRIEF.md
# Clock-Generator Control Register Slave

This block is the configuration front end of a clock generator. It listens on a two-wire SMBus-style bus as a slave. It holds the control bytes that set the output enables, the stop-mode selects, the spread settings and the divider override values for the synthesizer around it. The serial lines are oversampled on the system clock and pass through a two-flop synchronizer. START, STOP and SCL edges are found from the synchronized levels. The data line is pulled low only through an open-drain enable.

A write transaction carries the write address, a command byte whose value does not matter, a byte count, and then that many data bytes. The data bytes go into register 0, 1, 2 and so on. A read transaction carries the read address alone. The slave answers with the register count, then streams the registers from index 0 and wraps after the last one, until the master stops acknowledging. Some bits are read-only and show the live level of the strap and stop pins. One byte is a fixed signature. Every writable bit keeps its value across transactions until reset.

Top module: `smb_clkreg_slave`

## Requirements
- R1: An address byte other than 0xD2 (write) or 0xD3 (read) gets no acknowledge, and no register changes.
- R2: After 0xD2 the slave acknowledges the command byte whatever its value, then acknowledges the count byte. Data bytes then land in register 0, 1, 2 and onwards, one per acknowledged byte.
- R3: After reset, the registers hold 0x08 (byte 0, with only the internal PCI-run bit set), 0x07, 0x7F, 0xC7, 0x3F, 0x40, 0x13, 0x00, 0x00, 0x00. The configuration ports show these values.
- R4: Byte 0 reads back as {spread, pd_tristate, alt48, cpu_stop_n pin, PCI-run, freq_sel[2:0]}. Bit 4 and bits 2:0 always show the pins, and writes to them are ignored.
- R5: The PCI-run function (byte 0 bit 3 on read, and the pci_gate_n port) is the AND of the pci_stop_n pin and a writable internal bit. It is 0 when either one is 0.
- R6: Byte 1 bit 7 reads the mult_sel pin and ignores writes. Bits 6:0 are writable.
- R7: Byte 6 always reads 0x13. A write to it is acknowledged and its data is discarded.
- R8: Byte 7 reads 0. Byte 8 bits 6:0 drive pll_n. Byte 9 bits 6:1 drive pll_r and bit 0 drives pll_ovr. Bit 7 of bytes 8 and 9 reads 0.
- R9: After 0xD3 the slave sends the count 0x0A first, then bytes 0 to 9 in order, wrapping to 0. It releases the line for good once the master does not acknowledge.
- R10: Once the announced count of data bytes has been taken, any further byte gets no acknowledge and is not stored.
- R11: Registers that a transaction does not address keep their values.
- R12: SDA is driven (sda_oe high) only during acknowledge and read-data bit times. The drive changes only while SCL is low, and it is released at every START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| cpu_stop_n | input | 1 | CPU stop pin level, reflected in byte 0 bit 4 |
| pci_stop_n | input | 1 | PCI stop pin level, ANDed into the PCI-run function |
| freq_sel | input | 3 | Frequency straps, reflected in byte 0 bits 2:0 |
| mult_sel | input | 1 | Current-multiplier strap, reflected in byte 1 bit 7 |
| core_cfg | output | 3 | {spread enable, power-down tri-state, 48M select} from byte 0 |
| pci_gate_n | output | 1 | PCI-run function; 0 stops the stoppable PCI clocks |
| cpu_cfg | output | 7 | Byte 1 bits 6:0, CPU stop modes and enables |
| pci_en | output | 8 | Byte 2, PCI output controls |
| pcif_cfg | output | 8 | Byte 3, free-running PCI and 48M controls |
| aux_en | output | 8 | Byte 4, 66M output enables and spread bit |
| misc_cfg | output | 8 | Byte 5, spread, delay and edge-rate controls |
| pll_n | output | 7 | Divider N override value |
| pll_r | output | 6 | Divider R override value |
| pll_ovr | output | 1 | Selects the override N/R over the defaults |

## Verification
A fault in the byte pointer or the count shows up as the wrong byte in the next register read, or as a misplaced acknowledge within one byte time. A wrong register value shows on the configuration ports within a few clocks of that data byte's acknowledge. A fault in the read-only overlay appears in the first byte 0, 1 or 6 that is read after the pins change. A slip in the bit or phase state of the bus machine corrupts the next acknowledge or the next shifted bit. A drive enable that changes while SCL is high could create a false START or STOP. That is caught in the same cycle.

// File: rtl/smb_clkreg_pkg.sv
package smb_clkreg_pkg;

    localparam int NREG  = 10;
    localparam int IDX_W = 4;

    localparam logic [7:0] ADDR_WR = 8'hD2;
    localparam logic [7:0] ADDR_RD = 8'hD3;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RX_ACK,
        LK_TX,
        LK_TX_ACK
    } link_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    typedef struct packed {
        logic       cpu_stop_n;
        logic       pci_stop_n;
        logic       mult_sel;
        logic [2:0] freq_sel;
    } strap_t;

    // Bits a bus write may change, per register index
    function automatic logic [7:0] wr_mask(input int i);
        case (i)
            0:       return 8'hE8;
            1:       return 8'h7F;
            2, 3, 4, 5: return 8'hFF;
            8, 9:    return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    // Stored value after reset (read-only pin bits are stored as 0)
    function automatic logic [7:0] rst_val(input int i);
        case (i)
            0:       return 8'h08;
            1:       return 8'h07;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            5:       return 8'h40;
            6:       return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(NREG - 1)) ? '0 : i + 1'b1;
    endfunction

endpackage

// File: rtl/smb_bus_filter.sv
module smb_bus_filter #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC-1:0] scl_sh, sda_sh;
    logic            scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC-2:0], sda_i};
            scl_prev <= scl_sh[SYNC-1];
            sda_prev <= sda_sh[SYNC-1];
        end
    end

    assign scl_lvl   = scl_sh[SYNC-1];
    assign sda_lvl   = sda_sh[SYNC-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smb_clkreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_lvl,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output wr_req_t          wr,
    output logic             sda_oe
);
    localparam logic [7:0] COUNT_BYTE = 8'(NREG);

    link_st_e         st;
    rx_phase_e        ph;
    logic [7:0]       sh;
    logic [2:0]       bcnt;
    logic             full;
    logic             rd_mode;
    logic [7:0]       left;
    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LK_IDLE;
            ph      <= PH_ADDR;
            sh      <= '0;
            bcnt    <= '0;
            full    <= 1'b0;
            rd_mode <= 1'b0;
            left    <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_det) begin
                st     <= LK_RX;
                ph     <= PH_ADDR;
                bcnt   <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= LK_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    LK_RX: begin
                        if (scl_rise) begin
                            sh   <= {sh[6:0], sda_lvl};
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            case (ph)
                                PH_ADDR: begin
                                    if (sh == ADDR_WR || sh == ADDR_RD) begin
                                        sda_oe  <= 1'b1;
                                        st      <= LK_RX_ACK;
                                        rd_mode <= (sh == ADDR_RD);
                                        ptr     <= '0;
                                    end else begin
                                        st <= LK_IDLE;
                                    end
                                end
                                PH_CMD: begin
                                    sda_oe <= 1'b1;
                                    st     <= LK_RX_ACK;
                                end
                                PH_CNT: begin
                                    sda_oe <= 1'b1;
                                    st     <= LK_RX_ACK;
                                    left   <= sh;
                                    ptr    <= '0;
                                end
                                default: begin
                                    if (left != 8'd0) begin
                                        sda_oe <= 1'b1;
                                        st     <= LK_RX_ACK;
                                        left   <= left - 1'b1;
                                        wr     <= '{en: 1'b1, idx: ptr, data: sh};
                                    end else begin
                                        st <= LK_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    LK_RX_ACK: begin
                        if (scl_fall) begin
                            if (ph == PH_ADDR && rd_mode) begin
                                st     <= LK_TX;
                                sh     <= COUNT_BYTE;
                                sda_oe <= ~COUNT_BYTE[7];
                                bcnt   <= '0;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= LK_RX;
                                bcnt   <= '0;
                                case (ph)
                                    PH_ADDR: ph  <= PH_CMD;
                                    PH_CMD:  ph  <= PH_CNT;
                                    PH_CNT:  ph  <= PH_DATA;
                                    default: ptr <= next_idx(ptr);
                                endcase
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_fall) begin
                            if (bcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                st     <= LK_TX_ACK;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                                bcnt   <= bcnt + 1'b1;
                            end
                        end
                    end
                    LK_TX_ACK: begin
                        if (scl_rise) begin
                            if (sda_lvl) st <= LK_IDLE;
                        end else if (scl_fall) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bcnt   <= '0;
                            ptr    <= next_idx(ptr);
                            st     <= LK_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx = ptr;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_clkreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    input  logic [IDX_W-1:0] rd_idx,
    input  strap_t           pins,
    output logic [7:0]       rd_data,
    output logic [2:0]       core_cfg,
    output logic             pci_gate_n,
    output logic [6:0]       cpu_cfg,
    output logic [7:0]       pci_en,
    output logic [7:0]       pcif_cfg,
    output logic [7:0]       aux_en,
    output logic [7:0]       misc_cfg,
    output logic [6:0]       pll_n,
    output logic [5:0]       pll_r,
    output logic             pll_ovr
);
    logic [NREG-1:0][7:0] regs;
    logic [NREG-1:0][7:0] view;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [7:0] MASK = wr_mask(gi);
        always_ff @(posedge clk) begin
            if (rst)
                regs[gi] <= rst_val(gi);
            else if (wr.en && wr.idx == IDX_W'(gi))
                regs[gi] <= (regs[gi] & ~MASK) | (wr.data & MASK);
        end
    end

    always_comb begin
        view    = regs;
        view[0] = {regs[0][7:5],
                   regs[0][4] | pins.cpu_stop_n,
                   regs[0][3] & pins.pci_stop_n,
                   regs[0][2:0] | pins.freq_sel};
        view[1] = {regs[1][7] | pins.mult_sel, regs[1][6:0]};
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = view[i];
    end

    assign core_cfg   = regs[0][7:5];
    assign pci_gate_n = view[0][3];
    assign cpu_cfg    = regs[1][6:0];
    assign pci_en     = regs[2];
    assign pcif_cfg   = regs[3];
    assign aux_en     = regs[4];
    assign misc_cfg   = regs[5];
    assign pll_n      = regs[8][6:0];
    assign pll_r      = regs[9][6:1];
    assign pll_ovr    = regs[9][0];

endmodule

// File: rtl/smb_clkreg_slave.sv
module smb_clkreg_slave
    import smb_clkreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       cpu_stop_n,
    input  logic       pci_stop_n,
    input  logic [2:0] freq_sel,
    input  logic       mult_sel,
    output logic [2:0] core_cfg,
    output logic       pci_gate_n,
    output logic [6:0] cpu_cfg,
    output logic [7:0] pci_en,
    output logic [7:0] pcif_cfg,
    output logic [7:0] aux_en,
    output logic [7:0] misc_cfg,
    output logic [6:0] pll_n,
    output logic [5:0] pll_r,
    output logic       pll_ovr
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       rd_data;
    logic [IDX_W-1:0] rd_idx;
    wr_req_t          wr;
    strap_t           pins;

    assign pins = '{cpu_stop_n: cpu_stop_n, pci_stop_n: pci_stop_n,
                    mult_sel: mult_sel, freq_sel: freq_sel};

    smb_bus_filter #(.SYNC(2)) u_filt (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smb_link u_link (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr(wr), .sda_oe(sda_oe)
    );

    smb_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr(wr), .rd_idx(rd_idx), .pins(pins),
        .rd_data(rd_data), .core_cfg(core_cfg), .pci_gate_n(pci_gate_n),
        .cpu_cfg(cpu_cfg), .pci_en(pci_en), .pcif_cfg(pcif_cfg),
        .aux_en(aux_en), .misc_cfg(misc_cfg), .pll_n(pll_n),
        .pll_r(pll_r), .pll_ovr(pll_ovr)
    );

endmodule

// File: rtl/smb_clkreg_checker.sv
module smb_clkreg_checker
    import smb_clkreg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic             scl_lvl,
    input logic             scl_fall,
    input logic             start_det,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [5:0]       pll_r
);
    // R12: the drive only turns on just after an SCL falling edge
    p_oe_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    // R12: the drive never changes while SCL stays high
    p_oe_hold_high_r12: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R12: a START leaves the line released
    p_start_release_r12: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    // R2: a write strobe only addresses an existing register
    p_wr_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < IDX_W'(NREG)));

    // R11: the divider value only moves right after a write strobe
    p_pll_r_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(pll_r));

endmodule

bind smb_clkreg_slave smb_clkreg_checker u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
    .scl_fall(scl_fall), .start_det(start_det), .wr_en(wr.en),
    .wr_idx(wr.idx), .pll_r(pll_r)
);

// File: tb/test_smb_clkreg_slave.sv
`timescale 1ns/1ps
module test_smb_clkreg_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, mult_sel = 1'b1;
    logic [2:0] freq_sel = 3'b101;
    logic [2:0] core_cfg;
    logic pci_gate_n, pll_ovr;
    logic [6:0] cpu_cfg, pll_n;
    logic [7:0] pci_en, pcif_cfg, aux_en, misc_cfg;
    logic [5:0] pll_r;

    int tests = 0;
    int fails = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_byte;
    event       got_ev;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_clkreg_slave i_smb_clkreg_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .freq_sel(freq_sel),
        .mult_sel(mult_sel), .core_cfg(core_cfg), .pci_gate_n(pci_gate_n),
        .cpu_cfg(cpu_cfg), .pci_en(pci_en), .pcif_cfg(pcif_cfg), .aux_en(aux_en),
        .misc_cfg(misc_cfg), .pll_n(pll_n), .pll_r(pll_r), .pll_ovr(pll_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each byte read from the bus
    initial begin
        forever begin
            @(got_ev);
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9: actual %0h expected none", got_byte);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (got_byte !== e) begin
                    fails++;
                    $display("FAIL %s: actual %0h expected %0h", t, got_byte, e);
                end
            end
        end
    end

    task automatic expect_rd(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_m = 1'b0; wait_clk(Q);
        scl = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q); sda_m = b[i]; wait_clk(Q);
            scl = 1'b1; wait_clk(2 * Q); scl = 1'b0;
        end
        wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1; wait_clk(Q);
        acked = ~sda_line;
        wait_clk(Q); scl = 1'b0;
    endtask

    task automatic get_byte(input logic send_ack);
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
            scl = 1'b1; wait_clk(Q);
            b[i] = sda_line;
            wait_clk(Q); scl = 1'b0;
        end
        wait_clk(Q); sda_m = ~send_ack; wait_clk(Q);
        scl = 1'b1; wait_clk(2 * Q); scl = 1'b0;
        got_byte = b;
        ->got_ev;
    endtask

    task automatic read_txn(input int n);
        logic a;
        bus_start();
        put_byte(8'hD3, a);
        chk("R9 read address ack", a, 1);
        for (int i = 0; i < n; i++) get_byte(i != n - 1);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic a;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R3: reset values at the ports
        chk("R3 core_cfg", core_cfg, 3'b000);
        chk("R3 cpu_cfg", cpu_cfg, 7'h07);
        chk("R3 pci_en", pci_en, 8'h7F);
        chk("R3 pcif_cfg", pcif_cfg, 8'hC7);
        chk("R3 aux_en", aux_en, 8'h3F);
        chk("R3 misc_cfg", misc_cfg, 8'h40);
        chk("R3 pll", {pll_n, pll_r, pll_ovr}, 14'h0);
        chk("R3 pci_gate_n", pci_gate_n, 1);
        chk("R12 idle release", sda_oe, 0);

        // R1: foreign addresses are not acknowledged
        bus_start(); put_byte(8'hA0, a); bus_stop();
        chk("R1 nack A0", a, 0);
        bus_start(); put_byte(8'hD0, a); put_byte(8'h00, a); bus_stop();
        chk("R1 nack data after D0", a, 0);
        chk("R1 pci_en unchanged", pci_en, 8'h7F);

        // R2/R7/R8/R10: full block write then one excess byte
        bus_start();
        put_byte(8'hD2, a); chk("R2 write address ack", a, 1);
        put_byte(8'h5C, a); chk("R2 command ack", a, 1);
        put_byte(8'h0A, a); chk("R2 count ack", a, 1);
        put_byte(8'hFF, a); put_byte(8'hF5, a); put_byte(8'h12, a);
        put_byte(8'h34, a); put_byte(8'h56, a); put_byte(8'h78, a);
        put_byte(8'h99, a); chk("R7 signature write ack", a, 1);
        put_byte(8'hFF, a); put_byte(8'hFF, a); put_byte(8'hAB, a);
        chk("R2 last data ack", a, 1);
        put_byte(8'hEE, a); chk("R10 excess byte nack", a, 0);
        bus_stop();
        chk("R2 core_cfg", core_cfg, 3'b111);
        chk("R6 cpu_cfg", cpu_cfg, 7'h75);
        chk("R2 pci_en", pci_en, 8'h12);
        chk("R2 pcif_cfg", pcif_cfg, 8'h34);
        chk("R2 aux_en", aux_en, 8'h56);
        chk("R2 misc_cfg", misc_cfg, 8'h78);
        chk("R8 pll_n", pll_n, 7'h7F);
        chk("R8 pll_r", pll_r, 6'h15);
        chk("R8 pll_ovr", pll_ovr, 1);
        chk("R5 pci_gate_n pins high", pci_gate_n, 1);

        // R9: count, bytes 0..9, wrap to 0 and 1, NACK on last
        expect_rd(8'h0A, "R9 count");
        expect_rd(8'hFD, "R4 byte0");
        expect_rd(8'hF5, "R6 byte1");
        expect_rd(8'h12, "R9 byte2");
        expect_rd(8'h34, "R9 byte3");
        expect_rd(8'h56, "R9 byte4");
        expect_rd(8'h78, "R9 byte5");
        expect_rd(8'h13, "R7 byte6");
        expect_rd(8'h00, "R8 byte7");
        expect_rd(8'h7F, "R8 byte8");
        expect_rd(8'h2B, "R8 byte9");
        expect_rd(8'hFD, "R9 wrap byte0");
        expect_rd(8'hF5, "R9 wrap byte1");
        read_txn(13);
        chk("R12 released after read", sda_oe, 0);

        // R4/R5/R6: pins move, read-only bits follow
        pci_stop_n = 1'b0; cpu_stop_n = 1'b0; freq_sel = 3'b010; mult_sel = 1'b0;
        wait_clk(4);
        chk("R5 pci_gate_n pin low", pci_gate_n, 0);
        expect_rd(8'h0A, "R9 count");
        expect_rd(8'hE2, "R4 byte0 pins low");
        expect_rd(8'h75, "R6 byte1 mult low");
        read_txn(3);

        // R5/R11/R10: short write clears internal PCI-run bit
        pci_stop_n = 1'b1; cpu_stop_n = 1'b1; freq_sel = 3'b101; mult_sel = 1'b1;
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h02, a);
        put_byte(8'h00, a); put_byte(8'h00, a);
        put_byte(8'hEE, a); chk("R10 byte past count nack", a, 0);
        bus_stop();
        chk("R5 pci_gate_n internal low", pci_gate_n, 0);
        chk("R2 core_cfg cleared", core_cfg, 3'b000);
        chk("R11 pci_en kept", pci_en, 8'h12);
        chk("R11 pll_r kept", pll_r, 6'h15);
        expect_rd(8'h0A, "R9 count");
        expect_rd(8'h15, "R5 byte0 internal stop");
        expect_rd(8'h80, "R6 byte1 cleared");
        expect_rd(8'h12, "R11 byte2 kept");
        read_txn(4);

        wait_clk(10);
        if (exp_q.size() != 0) chk("R9 pending reads", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule